// File: doc/BRIEF.md
# Upcounting Timer Core with Buffered Reload

This block is a 16-bit upcounting timer for a register-mapped peripheral slot. Software programs a 16-bit control word and a reload limit through a small read/write port with byte strobes. Once enabled, the counter climbs by one each clock until it matches the active reload limit. It then returns to zero and emits a one-cycle update pulse.

The update event is where the buffered behaviour happens. When preload is off, a reload write acts on the counter at once. When preload is on, the written limit waits in a holding register and becomes active only at the next update event. Single-shot mode drops the enable at the update event, so the counter halts at zero. An update-inhibit bit suppresses the event altogether, but the count still wraps.

A debug-halt input, qualified by a stop-select input, can freeze the count. A two-bit divider field selects the rate of a single-cycle sampling strobe that is offered to downstream filter logic.

Top module: `upcount_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the reload limit reads 0xFFFF, the count is 0 and no update pulse is present.
- R2: The control word keeps only bit 0 (enable), bit 1 (update inhibit), bit 3 (single shot), bit 7 (preload) and bits 9:8 (divider); every other bit reads back as zero whatever was written, so writing 0xFFFE reads back 0x038A.
- R3: A write is accepted only when both strobes of the low half-word (bus_be[1:0] = 2'b11) are set, which 16-bit and 32-bit writes satisfy; any other strobe pattern leaves the addressed register unchanged. Reads ignore the strobes and always return the full word.
- R4: While enabled and not frozen, the count rises by one per clock. In the cycle after it equals the active limit it shows 0, and upd_pulse is high for exactly that cycle.
- R5: With preload clear, a write to the reload limit is used by the counter from the next clock.
- R6: With preload set, a written limit is held and reaches the counter only at the next update event; pulses are then spaced limit+1 cycles apart.
- R7: With single shot set, the update event clears the enable bit, and the counter rests at 0.
- R8: With update inhibit set, no update pulse is produced, the held limit is not loaded, and single shot does not clear the enable; the count still wraps at the active limit.
- R9: While dbg_halt and dbg_stop_cfg are both high the count holds and no update occurs; with dbg_stop_cfg low the counter runs through a halt.
- R10: smp_stb is a single-cycle strobe: divider 00 or 11 gives one every clock, 01 gives one every 2 clocks, 10 gives one every 4 clocks.
- R11: Word address 0 reads the control word, 1 reads the held reload limit, 2 reads the count and 3 reads zero, all zero-extended to 32 bits; bus_rdata is registered and valid on the cycle after bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 2 | Word address |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug halt indication |
| dbg_stop_cfg | input | 1 | Freeze the count while halted when high |
| cnt_out | output | 16 | Current count |
| upd_pulse | output | 1 | One-cycle update event pulse |
| smp_stb | output | 1 | Sampling-clock strobe |

## Verification
The properties assume that software does not change the control word through the bus on the same clock as an update event. The single-shot property excludes that cycle explicitly, and the bench orders its writes so that none lands on an enable-clearing wrap. The strobe-spacing property is only checked once the divider has held the divide-by-four setting for a cycle. The bench always lets the divider settle for several clocks before it measures strobe gaps. Reload limits are lowered only while the counter sits at zero, so the count never has to run past the limit and overflow.

// File: rtl/utmr_pkg.sv
`timescale 1ns/1ps
package utmr_pkg;
  localparam int CTL_W    = 16;
  localparam int EN_BIT   = 0;
  localparam int UDIS_BIT = 1;
  localparam int OPM_BIT  = 3;
  localparam int PRE_BIT  = 7;
  localparam int DIV_LSB  = 8;
  localparam logic [CTL_W-1:0] CTL_MASK = 16'h038B;

  localparam int REG_CTL = 0;
  localparam int REG_ARR = 1;
  localparam int REG_CNT = 2;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_2   = 2'b01,
    DIV_4   = 2'b10,
    DIV_RSV = 2'b11
  } div_e;

  typedef struct packed {
    div_e div;
    logic pre;
    logic opm;
    logic udis;
    logic en;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[EN_BIT]         = c.en;
    w[UDIS_BIT]       = c.udis;
    w[OPM_BIT]        = c.opm;
    w[PRE_BIT]        = c.pre;
    w[DIV_LSB +: 2]   = c.div;
    return w;
  endfunction

  function automatic ctl_t ctl_unpack(logic [CTL_W-1:0] w);
    ctl_t c;
    c.en   = w[EN_BIT];
    c.udis = w[UDIS_BIT];
    c.opm  = w[OPM_BIT];
    c.pre  = w[PRE_BIT];
    c.div  = div_e'(w[DIV_LSB +: 2]);
    return c;
  endfunction
endpackage

// File: rtl/utmr_regs.sv
`timescale 1ns/1ps
module utmr_regs
  import utmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd_evt,
  input  logic [CNT_W-1:0]  cnt,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  arr_act,
  output logic [DATA_W-1:0] rdata
);
  localparam int HW_BYTES = CTL_W / 8;

  logic [CNT_W-1:0] arr_buf;
  logic wr_ok, wr_ctl, wr_arr;
  logic unused_hi;

  // low half-word must be fully strobed for a write to land
  assign wr_ok  = wr && (&be[HW_BYTES-1:0]);
  assign wr_ctl = wr_ok && (addr == ADDR_W'(REG_CTL));
  assign wr_arr = wr_ok && (addr == ADDR_W'(REG_ARR));
  assign unused_hi = ^{be[DATA_W/8-1:HW_BYTES], wdata[DATA_W-1:CTL_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      arr_buf <= '1;
      arr_act <= '1;
      rdata   <= '0;
    end else begin
      // bus write wins over the hardware single-shot clear
      if (wr_ctl)
        ctl <= ctl_unpack(wdata[CTL_W-1:0]);
      else if (upd_evt && ctl.opm)
        ctl.en <= 1'b0;

      if (wr_arr)
        arr_buf <= wdata[CNT_W-1:0];

      if (wr_arr && !ctl.pre)
        arr_act <= wdata[CNT_W-1:0];
      else if (upd_evt && ctl.pre)
        arr_act <= arr_buf;

      if (rd) begin
        rdata <= '0;
        case (addr)
          ADDR_W'(REG_CTL): rdata[CTL_W-1:0] <= ctl_pack(ctl);
          ADDR_W'(REG_ARR): rdata[CNT_W-1:0] <= arr_buf;
          ADDR_W'(REG_CNT): rdata[CNT_W-1:0] <= cnt;
          default:          rdata            <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/utmr_count.sv
`timescale 1ns/1ps
module utmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             udis,
  input  logic             halt,
  input  logic             stop_cfg,
  input  logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_evt,
  output logic             upd_pulse
);
  logic run, at_top;

  assign run     = en && !(halt && stop_cfg);
  assign at_top  = (cnt == arr_act);
  assign upd_evt = run && at_top && !udis;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      upd_pulse <= 1'b0;
    end else begin
      if (run)
        cnt <= at_top ? '0 : cnt + 1'b1;
      upd_pulse <= upd_evt;
    end
  end
endmodule

// File: rtl/utmr_sdiv.sv
`timescale 1ns/1ps
module utmr_sdiv
  import utmr_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  div_e div,
  output logic stb
);
  logic [PH_W-1:0] ph;
  logic hit;

  always_comb begin
    case (div)
      DIV_2:   hit = ph[0];
      DIV_4:   hit = &ph[1:0];
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      stb <= 1'b0;
    end else begin
      ph  <= ph + 1'b1;
      stb <= hit;
    end
  end
endmodule

// File: rtl/upcount_timer.sv
`timescale 1ns/1ps
module upcount_timer
  import utmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  input  logic              dbg_stop_cfg,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              upd_pulse,
  output logic              smp_stb
);
  ctl_t             ctl;
  logic [CNT_W-1:0] arr_act;
  logic             upd_evt;

  utmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .upd_evt(upd_evt), .cnt(cnt_out),
    .ctl(ctl), .arr_act(arr_act), .rdata(bus_rdata)
  );

  utmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en(ctl.en), .udis(ctl.udis), .halt(dbg_halt),
    .stop_cfg(dbg_stop_cfg), .arr_act(arr_act), .cnt(cnt_out),
    .upd_evt(upd_evt), .upd_pulse(upd_pulse)
  );

  utmr_sdiv #(.PH_W(2)) u_sdiv (
    .clk(clk), .rst(rst), .div(ctl.div), .stb(smp_stb)
  );
endmodule

// File: rtl/utmr_chk.sv
`timescale 1ns/1ps
module utmr_chk
  import utmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              dbg_halt,
  input logic              dbg_stop_cfg,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              upd_pulse,
  input logic              smp_stb,
  input ctl_t              ctl,
  input logic [CNT_W-1:0]  arr_act
);
  logic [CTL_W-1:0] ctl_word;
  logic             frz;
  logic             ctl_wr_any;
  logic             ctl_part_wr;

  assign ctl_word    = ctl_pack(ctl);
  assign frz         = dbg_halt && dbg_stop_cfg;
  assign ctl_wr_any  = bus_wr && (bus_addr == ADDR_W'(REG_CTL));
  assign ctl_part_wr = ctl_wr_any && (bus_be[1:0] != 2'b11);

  // R4
  upd_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (cnt_out == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.en) && !$past(frz) && ($past(cnt_out) != $past(arr_act)))
      |-> (cnt_out == $past(cnt_out) + 1'b1));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frz |=> ($stable(cnt_out) && !upd_pulse));

  // R8
  inhibit_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.udis) |-> !upd_pulse);

  // R7
  one_shot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse && $past(ctl.opm) && !$past(ctl_wr_any)) |-> !ctl.en);

  // R3
  part_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl_part_wr) && !upd_pulse) |-> $stable(ctl_word));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && ($past(bus_addr) == ADDR_W'(REG_CTL)))
      |-> ((bus_rdata[CTL_W-1:0] & ~CTL_MASK) == '0 && bus_rdata[DATA_W-1:CTL_W] == '0));

  // R10
  stb_div4_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && ctl.div == DIV_4 && $past(ctl.div) == DIV_4) |-> !$past(smp_stb));
endmodule

bind upcount_timer utmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
  .dbg_stop_cfg(dbg_stop_cfg), .cnt_out(cnt_out), .upd_pulse(upd_pulse),
  .smp_stb(smp_stb), .ctl(ctl), .arr_act(arr_act)
);

// File: tb/test_upcount_timer.sv
`timescale 1ns/1ps
module test_upcount_timer;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              dbg_halt = 1'b0;
  logic              dbg_stop_cfg = 1'b0;
  logic [15:0]       cnt_out;
  logic              upd_pulse;
  logic              smp_stb;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  upcount_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_upcount_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .dbg_stop_cfg(dbg_stop_cfg), .cnt_out(cnt_out),
    .upd_pulse(upd_pulse), .smp_stb(smp_stb)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctl, m_buf, m_act, m_cnt;
  logic        m_upd;
  logic [31:0] m_rd;

  always @(posedge clk) begin : model
    logic run, top, ev, wok;
    logic [15:0] c_n, a_n, b_n;
    if (rst) begin
      m_ctl <= 16'h0000; m_buf <= 16'hFFFF; m_act <= 16'hFFFF;
      m_cnt <= 16'h0000; m_upd <= 1'b0;     m_rd  <= 32'h0;
    end else begin
      run = m_ctl[0] && !(dbg_halt && dbg_stop_cfg);
      top = (m_cnt == m_act);
      ev  = run && top && !m_ctl[1];
      wok = bus_wr && (bus_be[1:0] == 2'b11);
      c_n = m_ctl;
      if (ev && m_ctl[3]) c_n[0] = 1'b0;
      if (wok && bus_addr == 2'd0) c_n = bus_wdata[15:0] & 16'h038B;
      a_n = m_act;
      b_n = m_buf;
      if (ev && m_ctl[7]) a_n = m_buf;
      if (wok && bus_addr == 2'd1) begin
        b_n = bus_wdata[15:0];
        if (!m_ctl[7]) a_n = bus_wdata[15:0];
      end
      if (bus_rd) begin
        case (bus_addr)
          2'd0:    m_rd <= {16'h0, m_ctl};
          2'd1:    m_rd <= {16'h0, m_buf};
          2'd2:    m_rd <= {16'h0, m_cnt};
          default: m_rd <= 32'h0;
        endcase
      end
      if (run) m_cnt <= top ? 16'h0 : m_cnt + 16'h1;
      m_upd <= ev;
      m_ctl <= c_n;
      m_act <= a_n;
      m_buf <= b_n;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 count", {16'h0, cnt_out}, {16'h0, m_cnt});
      check("R4 update pulse", {31'h0, upd_pulse}, {31'h0, m_upd});
      check("R11 read data", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic bus_read_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = 4'h1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'h0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_gap(output int g);
    do @(negedge clk); while (!upd_pulse);
    g = 0;
    do begin @(negedge clk); g++; end while (!upd_pulse);
  endtask

  task automatic stb_gap_chk(input logic [1:0] dv, input int exp, input string req);
    int n;
    bus_write(2'd0, 4'hF, {22'h0, dv, 8'h00});
    idle(6);
    do @(negedge clk); while (!smp_stb);
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!smp_stb);
      check(req, n, exp);
    end
  endtask

  task automatic report;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int g, pc;
    logic [15:0] held;
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 count after reset", {16'h0, cnt_out}, 32'h0);
    check("R1 no pulse after reset", {31'h0, upd_pulse}, 32'h0);
    bus_read_chk(2'd0, 32'h0000, "R1 control reset");
    bus_read_chk(2'd1, 32'hFFFF, "R1 reload reset");

    // R2 reserved bits, counter kept disabled
    bus_write(2'd0, 4'h3, 32'hFFFF_FFFE);
    bus_read_chk(2'd0, 32'h038A, "R2 reserved read zero");
    bus_write(2'd0, 4'hF, 32'h0);

    // R3 partial-strobe writes ignored
    bus_write(2'd0, 4'h1, 32'h0000_0081);
    bus_read_chk(2'd0, 32'h0000, "R3 byte write ignored");
    bus_write(2'd0, 4'hC, 32'h0081_0081);
    bus_read_chk(2'd0, 32'h0000, "R3 upper half write ignored");
    bus_write(2'd1, 4'h2, 32'h0000_0005);
    bus_read_chk(2'd1, 32'hFFFF, "R3 reload byte write ignored");

    // R5 immediate reload, R7 single shot
    bus_write(2'd1, 4'hF, 32'h5);
    bus_write(2'd0, 4'h3, 32'h0009);
    idle(14);
    bus_read_chk(2'd0, 32'h0008, "R7 enable cleared");
    check("R7 rests at zero", {16'h0, cnt_out}, 32'h0);

    bus_write(2'd1, 4'h3, 32'h3);
    bus_write(2'd0, 4'hF, 32'h0001);
    pulse_gap(g);
    check("R5 immediate reload gap", g, 4);

    // R6 buffered reload
    bus_write(2'd0, 4'hF, 32'h0081);
    bus_write(2'd1, 4'hF, 32'h7);
    pulse_gap(g);
    pulse_gap(g);
    check("R6 buffered reload gap", g, 8);
    bus_read_chk(2'd1, 32'h7, "R11 held reload readback");

    // R8 update inhibit
    bus_write(2'd0, 4'hF, 32'h0083);
    bus_write(2'd1, 4'hF, 32'h2);
    pc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (upd_pulse) pc++;
    end
    check("R8 no pulses while inhibited", pc, 0);
    bus_write(2'd0, 4'hF, 32'h0081);
    pulse_gap(g);
    pulse_gap(g);
    check("R8 held limit loaded after release", g, 3);

    // R9 debug halt
    @(negedge clk);
    dbg_halt = 1'b1;
    idle(6);
    dbg_stop_cfg = 1'b1;
    @(negedge clk);
    held = cnt_out;
    pc = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (upd_pulse) pc++;
    end
    check("R9 frozen count", {16'h0, cnt_out}, {16'h0, held});
    check("R9 no pulse while frozen", pc, 0);
    @(negedge clk);
    dbg_halt = 1'b0;
    dbg_stop_cfg = 1'b0;
    idle(4);

    // R8 single shot suppressed by inhibit
    bus_write(2'd0, 4'hF, 32'h008B);
    idle(12);
    bus_read_chk(2'd0, 32'h008B, "R8 enable kept under inhibit");

    // stop and check read map
    bus_write(2'd0, 4'hF, 32'h0000);
    idle(2);
    bus_read_chk(2'd2, {16'h0, cnt_out}, "R11 count readback");
    bus_read_chk(2'd3, 32'h0, "R11 unmapped reads zero");

    // R10 strobe rates
    stb_gap_chk(2'b00, 1, "R10 divider 00");
    stb_gap_chk(2'b01, 2, "R10 divider 01");
    stb_gap_chk(2'b10, 4, "R10 divider 10");
    stb_gap_chk(2'b11, 1, "R10 divider 11");

    idle(3);
    report();
  end
endmodule